// File: doc/BRIEF.md
# Adaptive DC Offset Canceller

This block estimates the slowly varying DC component of a 14-bit signed sample stream and, when asked to, subtracts it from every sample. The estimate is held in a first-order leaky integrator with fractional guard bits. Each accepted sample moves the integrator towards the sample by the difference shifted right by an exponent k. A small k tracks quickly, and a large k gives a narrow, slow loop.

The integrator keeps running whether or not correction is applied, so turning correction on takes effect on the very next sample. A 16-bit view of the estimate (the integer sample part plus two fraction bits) can be fetched one byte at a time. Reading the low byte freezes a copy of the high byte, so that a two-byte fetch is coherent even while the estimate keeps moving.

Top module: `dc_offset_canceller`

## Requirements
- R1: While `rst_n` is low at a rising edge, the integrator is cleared to zero, `corr_vld` and `corr_smp` go to 0, and the readback byte and frozen high byte go to 0.
- R2: On each edge with `smp_vld` high, the 27-bit integrator A (14 integer bits over 13 fraction bits) becomes A + floor(((x·2^13) − A) / 2^ke). With k = 0, A becomes exactly x·2^13.
- R3: The effective exponent is ke = min(`shift_k`, 13). The values 14 and 15 behave exactly like 13.
- R4: The 16-bit estimate equals floor(A / 2^11). It covers the full input range with two fraction bits.
- R5: With `corr_en` high at the sample edge, the output is x − floor(A / 2^13). A is the value held before that sample's update.
- R6: With `corr_en` low at the sample edge, the output equals x unchanged.
- R7: A corrected result above 8191 is output as 8191, and one below −8192 as −8192. It never wraps.
- R8: The integrator updates whatever `corr_en` is. Enabling correction therefore uses the estimate built up while it was off.
- R9: A readback request with `rb_sel`=0 returns estimate bits [7:0] and freezes bits [15:8]. A request with `rb_sel`=1 returns the frozen byte, even if the estimate moved in between. `rb_data` is valid one cycle after the request.
- R10: `corr_vld` is high exactly one cycle after each edge with `smp_vld` high, and `corr_smp` is updated in that same cycle. `corr_smp` holds its value when no sample arrives.
- R11: Edges with `smp_vld` low leave the integrator, and so the estimate, unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_vld | input | 1 | Sample strobe |
| smp_in | input | 14 | Signed input sample |
| shift_k | input | 4 | Loop bandwidth exponent |
| corr_en | input | 1 | Apply correction when high |
| corr_vld | output | 1 | Output sample strobe |
| corr_smp | output | 14 | Signed output sample |
| rb_req | input | 1 | Readback request |
| rb_sel | input | 1 | 0 = low byte (freezes high), 1 = frozen high byte |
| rb_data | output | 8 | Readback byte |

## Verification
A corrected sample is due one edge after its strobe. It is computed from the integrator value before that same edge's update. A readback byte is due one edge after its request. The bench drives every input on the falling edge and sets the strobe for one cycle only. It then compares `corr_smp`, `corr_vld` and `rb_data` at the next falling edge, against an arithmetic model that applies the update only after the expected output has been taken. Estimates are read back only in idle cycles, so the model and the design hold the same integrator value at each compare.

// File: rtl/dcoc_pkg.sv
// Shared widths and saturation helper for the DC offset canceller.
package dcoc_pkg;
    localparam int SMP_W  = 14;   // sample width
    localparam int FRAC_W = 13;   // guard fraction bits in the integrator
    localparam int EST_W  = 16;   // readback estimate width
    localparam int K_W    = 4;    // exponent field width
    localparam int K_MAX  = 13;   // largest effective exponent

    // Clamp a (SMP_W+1)-bit signed value into SMP_W-bit signed range.
    function automatic logic signed [SMP_W-1:0] sat_smp(input logic signed [SMP_W:0] v);
        logic signed [SMP_W:0] hi;
        logic signed [SMP_W:0] lo;
        hi = (SMP_W+1)'((1 << (SMP_W-1)) - 1);
        lo = -(SMP_W+1)'(1 << (SMP_W-1));
        if (v > hi)      return hi[SMP_W-1:0];
        else if (v < lo) return lo[SMP_W-1:0];
        else             return v[SMP_W-1:0];
    endfunction
endpackage

// File: rtl/dcoc_tracker.sv
// Leaky integrator tracking the DC level of the sample stream.
// Assumes: FRAC_W >= K_MAX so the integer estimate settles within one LSB,
// and EST_W > SMP_W with EST_W <= SMP_W + FRAC_W.
module dcoc_tracker #(
    parameter int SMP_W  = dcoc_pkg::SMP_W,
    parameter int FRAC_W = dcoc_pkg::FRAC_W,
    parameter int EST_W  = dcoc_pkg::EST_W,
    parameter int K_W    = dcoc_pkg::K_W,
    parameter int K_MAX  = dcoc_pkg::K_MAX
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    smp_vld,
    input  logic signed [SMP_W-1:0] smp_in,
    input  logic        [K_W-1:0]   shift_k,
    output logic signed [SMP_W-1:0] dc_int,
    output logic        [EST_W-1:0] dc_est
);
    localparam int ACC_W = SMP_W + FRAC_W;
    localparam int DIF_W = ACC_W + 1;

    logic signed [ACC_W-1:0] acc_q;
    logic        [K_W-1:0]   k_eff;
    logic signed [DIF_W-1:0] target;
    logic signed [DIF_W-1:0] diff;
    logic signed [DIF_W-1:0] step;
    logic signed [DIF_W-1:0] acc_sum;

    // Clamp the exponent to the largest supported value.
    always_comb begin
        if (shift_k > K_W'(K_MAX)) k_eff = K_W'(K_MAX);
        else                       k_eff = shift_k;
    end

    // Compute the next integrator value from the error shifted by k.
    always_comb begin
        target  = {smp_in[SMP_W-1], smp_in, {FRAC_W{1'b0}}};
        diff    = target - {acc_q[ACC_W-1], acc_q};
        step    = diff >>> k_eff;
        acc_sum = {acc_q[ACC_W-1], acc_q} + step;
    end

    // Integrator register, cleared by reset, moves only on samples.
    always_ff @(posedge clk) begin
        if (!rst_n)       acc_q <= '0;
        else if (smp_vld) acc_q <= acc_sum[ACC_W-1:0];
    end

    // Integer part for subtraction, wider view for readback.
    assign dc_int = acc_q[ACC_W-1:FRAC_W];
    assign dc_est = acc_q[ACC_W-1:ACC_W-EST_W];

    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_vld |=> $stable(acc_q));
    assert_k0_snap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && shift_k == '0) |=> (acc_q == {$past(smp_in), {FRAC_W{1'b0}}}));
endmodule

// File: rtl/dcoc_apply.sv
// Subtracts the integer DC estimate from a sample and saturates, or passes
// the sample through when correction is off. One register stage.
module dcoc_apply #(
    parameter int SMP_W = dcoc_pkg::SMP_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    smp_vld,
    input  logic signed [SMP_W-1:0] smp_in,
    input  logic                    corr_en,
    input  logic signed [SMP_W-1:0] dc_int,
    output logic                    out_vld,
    output logic signed [SMP_W-1:0] out_smp
);
    localparam logic signed [SMP_W:0] MAX_V = (SMP_W+1)'((1 << (SMP_W-1)) - 1);

    logic signed [SMP_W:0]   wide_diff;
    logic signed [SMP_W-1:0] next_smp;

    // Form the corrected (clamped) or bypassed sample.
    always_comb begin
        wide_diff = {smp_in[SMP_W-1], smp_in} - {dc_int[SMP_W-1], dc_int};
        next_smp  = corr_en ? dcoc_pkg::sat_smp(wide_diff) : smp_in;
    end

    // Output register: value held between samples, strobe pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld <= 1'b0;
            out_smp <= '0;
        end else begin
            out_vld <= smp_vld;
            if (smp_vld) out_smp <= next_smp;
        end
    end

    assert_bypass_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && !corr_en) |=> (out_smp == $past(smp_in)));
    assert_clip_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && corr_en && wide_diff > MAX_V) |=> (out_smp == MAX_V[SMP_W-1:0]));
    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_vld |=> $stable(out_smp));
endmodule

// File: rtl/dcoc_readback.sv
// Two-byte coherent readback of the estimate: reading the low byte
// freezes the high byte for a later high-byte read.
module dcoc_readback #(
    parameter int EST_W = dcoc_pkg::EST_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EST_W-1:0] dc_est,
    input  logic             rb_req,
    input  logic             rb_sel,
    output logic [7:0]       rb_data
);
    logic [7:0] hi_hold;

    // Serve the requested byte and snapshot the high byte on a low read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_hold <= '0;
            rb_data <= '0;
        end else if (rb_req) begin
            if (!rb_sel) begin
                rb_data <= dc_est[7:0];
                hi_hold <= dc_est[15:8];
            end else begin
                rb_data <= hi_hold;
            end
        end
    end

    assert_snapshot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rb_req && !rb_sel) |=> (hi_hold == $past(dc_est[15:8])));
    assert_hold_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(rb_req && !rb_sel) |=> $stable(hi_hold));
endmodule

// File: rtl/dc_offset_canceller.sv
// Top: DC tracker, correction stage and byte readback of the estimate.
// Assumes one sample per strobe; the corrected sample uses the estimate
// held before that sample's own update.
module dc_offset_canceller #(
    parameter int SMP_W  = dcoc_pkg::SMP_W,
    parameter int FRAC_W = dcoc_pkg::FRAC_W,
    parameter int EST_W  = dcoc_pkg::EST_W,
    parameter int K_W    = dcoc_pkg::K_W,
    parameter int K_MAX  = dcoc_pkg::K_MAX
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    smp_vld,
    input  logic signed [SMP_W-1:0] smp_in,
    input  logic        [K_W-1:0]   shift_k,
    input  logic                    corr_en,
    output logic                    corr_vld,
    output logic signed [SMP_W-1:0] corr_smp,
    input  logic                    rb_req,
    input  logic                    rb_sel,
    output logic [7:0]              rb_data
);
    logic signed [SMP_W-1:0] dc_int;
    logic        [EST_W-1:0] dc_est;

    dcoc_tracker #(.SMP_W(SMP_W), .FRAC_W(FRAC_W), .EST_W(EST_W),
                   .K_W(K_W), .K_MAX(K_MAX)) trk_i (
        .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_in(smp_in),
        .shift_k(shift_k), .dc_int(dc_int), .dc_est(dc_est));

    dcoc_apply #(.SMP_W(SMP_W)) app_i (
        .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_in(smp_in),
        .corr_en(corr_en), .dc_int(dc_int), .out_vld(corr_vld), .out_smp(corr_smp));

    dcoc_readback #(.EST_W(EST_W)) rb_i (
        .clk(clk), .rst_n(rst_n), .dc_est(dc_est), .rb_req(rb_req),
        .rb_sel(rb_sel), .rb_data(rb_data));

    assert_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        smp_vld |=> corr_vld);
    assert_no_spurious_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_vld |=> !corr_vld);
endmodule

// File: tb/dc_offset_canceller_tb.sv
module dc_offset_canceller_tb_top;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              smp_vld = 1'b0;
    logic signed [13:0] smp_in = '0;
    logic [3:0]        shift_k = '0;
    logic              corr_en = 1'b0;
    logic              corr_vld;
    logic signed [13:0] corr_smp;
    logic              rb_req = 1'b0;
    logic              rb_sel = 1'b0;
    logic [7:0]        rb_data;

    int checks = 0;
    int failures = 0;
    longint acc_m = 0;

    always #2.5 clk = ~clk;

    dc_offset_canceller dut_i (
        .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_in(smp_in),
        .shift_k(shift_k), .corr_en(corr_en), .corr_vld(corr_vld),
        .corr_smp(corr_smp), .rb_req(rb_req), .rb_sel(rb_sel), .rb_data(rb_data));

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint keff(input int k);
        return (k > 13) ? 13 : k;
    endfunction

    function automatic longint est_m();
        return (acc_m >>> 11) & 16'hFFFF;
    endfunction

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0; smp_vld = 1'b0; rb_req = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
        acc_m = 0;
        check("R1 vld", corr_vld, 0);
        check("R1 smp", corr_smp, 0);
        check("R1 rb", rb_data, 0);
    endtask

    // Push one sample; expected output from pre-update model (R5/R6/R7/R10).
    task automatic push(input int x, input string tag);
        longint dc, y;
        @(negedge clk); smp_vld = 1'b1; smp_in = 14'(x);
        dc = acc_m >>> 13;
        if (corr_en) begin
            y = x - dc;
            if (y > 8191) y = 8191;
            if (y < -8192) y = -8192;
        end else y = x;
        acc_m = acc_m + (((longint'(x)) <<< 13) - acc_m >>> keff(int'(shift_k)));
        @(negedge clk); smp_vld = 1'b0;
        check({tag, " R10 vld"}, corr_vld, 1);
        check(tag, longint'(corr_smp), y);
    endtask

    task automatic read_byte(input bit sel, output logic [7:0] b);
        @(negedge clk); rb_req = 1'b1; rb_sel = sel;
        @(negedge clk); rb_req = 1'b0;
        b = rb_data;
    endtask

    task automatic read_est(input string tag);
        logic [7:0] lo, hi;
        read_byte(1'b0, lo);
        read_byte(1'b1, hi);
        check(tag, {hi, lo}, est_m());
    endtask

    initial begin
        #(5.0 * 150000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [7:0] b, lo;
        longint old_hi;
        do_reset();
        read_est("R1 est zero");

        // k = 0 snap (R2), estimate format (R4)
        shift_k = 4'd0; corr_en = 1'b0;
        push(-1234, "R6 bypass");
        read_est("R2 R4 k0 snap");
        check("R4 est value", est_m(), (-1234 * 4) & 16'hFFFF);

        // idle cycles leave estimate unchanged (R11)
        repeat (10) @(negedge clk);
        read_est("R11 idle hold");

        // saturation (R7)
        corr_en = 1'b1;
        push(8191, "R5");
        push(-8192, "R7 low clip");
        check("R7 low value", corr_smp, -8192);
        push(8191, "R7 high clip");
        check("R7 high value", corr_smp, 8191);

        // snapshot coherence (R9)
        push(100, "R5");
        read_byte(1'b0, lo);
        old_hi = (est_m() >> 8) & 8'hFF;
        check("R9 low byte", lo, est_m() & 8'hFF);
        push(-5000, "R5");
        read_byte(1'b1, b);
        check("R9 frozen high", b, old_hi);

        // sweep every exponent, toggling enable (R2 R3 R5 R6 R8)
        for (int k = 0; k < 16; k++) begin
            int off;
            do_reset();
            shift_k = 4'(k);
            off = (k * 1237) % 8000 - 4000;
            for (int i = 0; i < 400; i++) begin
                corr_en = ((i / 50) % 2) == 1;
                push(off + ((i * 97) % 2001) - 1000,
                     k > 13 ? "R3 clamp" : (corr_en ? "R5 R8 track" : "R6 R8 bypass"));
            end
            read_est(k > 13 ? "R3 est" : "R2 est");
        end

        // burst of back-to-back samples then enable (R8 R10)
        do_reset();
        shift_k = 4'd3; corr_en = 1'b0;
        for (int i = 0; i < 60; i++) push(3000 + (i % 7), "R8 off");
        corr_en = 1'b1;
        push(3003, "R8 immediate");
        read_est("R8 est");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule